// File: doc/BRIEF.md
# Segmented Carry-Select Adder/Subtractor

This block adds or subtracts two 16-bit unsigned or two's-complement operands in pure combinational logic. The word is cut into three slices: bits 4..0, bits 9..5 and bits 15..10. The bottom slice is a plain ripple chain of full adders. Each of the two upper slices is built twice. One copy assumes that no carry enters the slice, and the other assumes that a carry enters it. When the real carry arrives from the slice below, a multiplexer passes on the matching sum and carry. These multiplexers form a serial chain, so the worst path is one 5-bit ripple plus two selects, and not a full 16-bit ripple.

Subtraction uses the same hardware. The second operand is inverted bit by bit, and a 1 is fed in as the carry into the bottom slice. The block has no clock and no state. Its outputs follow its inputs within the same evaluation, so it can sit inside a single-cycle datapath.

Top module: `csel_addsub`

## Requirements
- R1: With `op_sub` = 0, {`carry_out`, `result`} equals the 17-bit unsigned sum of `opnd_a` and `opnd_b`.
- R2: With `op_sub` = 1, `result` equals `opnd_a` − `opnd_b` modulo 2^16, and `carry_out` is 1 exactly when `opnd_a` ≥ `opnd_b` (unsigned), that is, when no borrow occurs.
- R3: A carry that leaves bit 4 or bit 9 is delivered into bit 5 or bit 10 respectively. For example, 0x001F + 0x0001 = 0x0020 and 0x03FF + 0x0001 = 0x0400.
- R4: A carry out of bit 15 appears on `carry_out` (unsigned overflow). For example, 0xFFFF + 0x0001 gives `result` = 0x0000 and `carry_out` = 1.
- R5: When a carry enters at bit 0 and ripples through every slice, the result is correct. For example, subtracting 0x0000 from 0xFFFF gives `result` = 0xFFFF and `carry_out` = 1. Subtracting zero from any value returns that value with `carry_out` = 1.
- R6: Each upper slice keeps two candidate results. The carry-in-1 candidate always equals the carry-in-0 candidate plus one, taken over the slice width plus its carry.
- R7: Each slice's ripple chain produces the exact sum of its slice operands and its carry-in.
- R8: The block is combinational. Outputs settle after an input change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | First operand (minuend when subtracting) |
| opnd_b | input | 16 | Second operand (subtrahend when subtracting) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| result | output | 16 | Sum or difference, modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15; when subtracting, 1 means no borrow |

## Verification
The bench targets carries that must cross the 4/5 and 9/10 slice boundaries. A select line wired to the wrong slice, or an upper copy tied to the wrong assumed carry, would produce results wrong by exactly 32 or 1024. All-ones and 0x8000 operands push carries through the full width. A swapped multiplexer leg in the top slice would then drop or invent `carry_out`. Subtracting zero, equal operands and a larger subtrahend exercise the forced carry-in and the inverted operand. A design that omitted either one would be off by one, or would report the borrow sense backwards.

// File: rtl/csel_pkg.sv
// Package csel_pkg
// Holds the default geometry shared by the adder and its slices.
// Assumes the bottom and middle slice widths sum to less than the word width.
package csel_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned LOW_W  = 5;
    localparam int unsigned MID_W  = 5;
endpackage

// File: rtl/csel_fa.sv
// Module csel_fa
// One-bit full adder cell: sum is the parity of the three inputs,
// and carry is the majority of the three inputs. It holds no state.
module csel_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    // parity gives the sum bit
    assign s  = x ^ y ^ ci;
    // majority gives the carry bit
    assign co = (x & y) | (x & ci) | (y & ci);
endmodule

// File: rtl/csel_ripple.sv
// Module csel_ripple
// Ripple-carry chain of SEG_W full adders. Assumes SEG_W >= 1.
// Carries its own check that the chain matches exact arithmetic.
module csel_ripple #(
    parameter int unsigned SEG_W = 5
) (
    input  logic [SEG_W-1:0] x,
    input  logic [SEG_W-1:0] y,
    input  logic             ci,
    output logic [SEG_W-1:0] s,
    output logic             co
);
    logic [SEG_W:0] chain;

    assign chain[0] = ci;

    genvar k;
    generate
        for (k = 0; k < SEG_W; k++) begin : g_bit
            csel_fa u_fa (
                .x  (x[k]),
                .y  (y[k]),
                .ci (chain[k]),
                .s  (s[k]),
                .co (chain[k+1])
            );
        end
    endgenerate

    assign co = chain[SEG_W];

    // checks the gate chain against a wide arithmetic sum (R7)
    always_comb begin
        logic [SEG_W:0] exact_v;
        exact_v = {1'b0, x} + {1'b0, y} + {{SEG_W{1'b0}}, ci};
        a_r7_ripple_exact: assert ({co, s} == exact_v)
            else $error("R7 ripple mismatch");
    end
endmodule

// File: rtl/csel_dual.sv
// Module csel_dual
// Upper slice: two ripple copies, one assuming carry-in 0 and one
// assuming carry-in 1. The late incoming carry picks one of them.
// Assumes the incoming carry settles last.
module csel_dual #(
    parameter int unsigned SEG_W = 5
) (
    input  logic [SEG_W-1:0] x,
    input  logic [SEG_W-1:0] y,
    input  logic             pick,
    output logic [SEG_W-1:0] s,
    output logic             co
);
    logic [SEG_W-1:0] s_c0, s_c1;
    logic             co_c0, co_c1;

    csel_ripple #(.SEG_W(SEG_W)) u_c0 (
        .x(x), .y(y), .ci(1'b0), .s(s_c0), .co(co_c0)
    );
    csel_ripple #(.SEG_W(SEG_W)) u_c1 (
        .x(x), .y(y), .ci(1'b1), .s(s_c1), .co(co_c1)
    );

    // selects the candidate that matches the real incoming carry
    always_comb begin
        if (pick) begin
            s  = s_c1;
            co = co_c1;
        end else begin
            s  = s_c0;
            co = co_c0;
        end
    end

    // the two independent copies must differ by exactly one (R6)
    always_comb begin
        a_r6_copies_step: assert ({co_c1, s_c1} == {co_c0, s_c0} + 1'b1)
            else $error("R6 candidate copies disagree");
    end
endmodule

// File: rtl/csel_addsub.sv
// Module csel_addsub
// Top: a 16-bit adder/subtractor built as a low ripple slice and two
// duplicated upper slices joined by a serial select chain. Subtraction
// inverts the second operand and feeds a 1 into the bottom slice.
// Purely combinational.
module csel_addsub
    import csel_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned LW = LOW_W,
    parameter int unsigned MW = MID_W
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         op_sub,
    output logic [W-1:0] result,
    output logic         carry_out
);
    localparam int unsigned HW    = W - LW - MW;
    localparam int unsigned MID_L = LW;
    localparam int unsigned HI_L  = LW + MW;

    logic [W-1:0] b_eff;
    logic         c_low, c_mid;

    // conditional inversion of the second operand
    assign b_eff = opnd_b ^ {W{op_sub}};

    csel_ripple #(.SEG_W(LW)) u_low (
        .x  (opnd_a[LW-1:0]),
        .y  (b_eff[LW-1:0]),
        .ci (op_sub),
        .s  (result[LW-1:0]),
        .co (c_low)
    );

    csel_dual #(.SEG_W(MW)) u_mid (
        .x    (opnd_a[HI_L-1:MID_L]),
        .y    (b_eff[HI_L-1:MID_L]),
        .pick (c_low),
        .s    (result[HI_L-1:MID_L]),
        .co   (c_mid)
    );

    csel_dual #(.SEG_W(HW)) u_high (
        .x    (opnd_a[W-1:HI_L]),
        .y    (b_eff[W-1:HI_L]),
        .pick (c_mid),
        .s    (result[W-1:HI_L]),
        .co   (carry_out)
    );

    // whole-word checks of add and subtract behaviour
    always_comb begin
        if (!op_sub) begin
            a_r1_add_exact: assert ({carry_out, result} == {1'b0, opnd_a} + {1'b0, opnd_b})
                else $error("R1 add mismatch");
        end else begin
            a_r2_no_borrow: assert (carry_out == (opnd_a >= opnd_b))
                else $error("R2 borrow sense wrong");
            if (opnd_b == '0) begin
                a_r5_sub_zero: assert (carry_out && (result == opnd_a))
                    else $error("R5 subtract zero wrong");
            end
        end
    end
endmodule

// File: tb/sim_csel_addsub.sv
// Bench for csel_addsub: directed corners plus seeded random operands,
// compared with expectations built from plain 17-bit arithmetic.
module sim_csel_addsub;
    logic        clk = 1'b0;
    logic [15:0] a, b;
    logic        sub;
    logic [15:0] result;
    logic        carry_out;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #4 clk = ~clk;

    csel_addsub u0 (
        .opnd_a(a), .opnd_b(b), .op_sub(sub),
        .result(result), .carry_out(carry_out)
    );

    function automatic logic [16:0] want_of(input logic [15:0] x, input logic [15:0] y, input logic s);
        logic [16:0] r;
        if (s) begin
            r[15:0] = x - y;
            r[16]   = (x >= y);
        end else begin
            r = {1'b0, x} + {1'b0, y};
        end
        return r;
    endfunction

    task automatic apply(input string tag, input logic [15:0] x, input logic [15:0] y, input logic s);
        logic [16:0] w;
        @(negedge clk);
        a = x; b = y; sub = s;
        #1;
        w = want_of(x, y, s);
        n_chk++;
        if ({carry_out, result} !== w) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h sub=%0d got=%h exp=%h", tag, x, y, s, {carry_out, result}, w);
        end
    endtask

    initial begin
        a = '0; b = '0; sub = 1'b0;
        #2;
        n_chk++;
        if ({carry_out, result} !== 17'h0) begin
            n_bad++;
            $display("FAIL R8 idle got=%h exp=%h", {carry_out, result}, 17'h0);
        end
        apply("R1", 16'd43, 16'd29, 1'b0);
        apply("R1", 16'h1234, 16'h4321, 1'b0);
        apply("R3", 16'h001F, 16'h0001, 1'b0);
        apply("R3", 16'h03FF, 16'h0001, 1'b0);
        apply("R3", 16'h03E0, 16'h0020, 1'b0);
        apply("R4", 16'hFFFF, 16'h0001, 1'b0);
        apply("R4", 16'h8000, 16'h8000, 1'b0);
        apply("R4", 16'hFFFF, 16'hFFFF, 1'b0);
        apply("R5", 16'hFFFF, 16'h0000, 1'b1);
        apply("R5", 16'h0000, 16'h0000, 1'b1);
        apply("R5", 16'h8000, 16'h0000, 1'b1);
        apply("R2", 16'h0005, 16'h0009, 1'b1);
        apply("R2", 16'h8000, 16'h8000, 1'b1);
        apply("R2", 16'h0000, 16'hFFFF, 1'b1);
        apply("R2", 16'hFFFF, 16'h8000, 1'b1);
        // random mix exercises R6 and R7 slice checks as well
        void'($urandom(32'h5EED_0C5A));
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (i % 7 == 0) ra = 16'hFFFF;
            if (i % 11 == 0) rb = 16'h8000;
            apply((i % 2) ? "R2" : "R1", ra, rb, 1'(i % 2));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog expired got=hang exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule